// File: doc/BRIEF.md
# Periodic Auto-Reset Pulse Generator

This block produces the reset for a small low-power controller. It holds reset while the supply-good level is low. It then adds a fixed-length pulse after that level rises. It also fires unconditionally in two other cases: once every 2^PERIOD_LOG2 cycles of the system clock, and each time the device leaves its low-power halt state. No input can delay or suppress the periodic pulse.

Every flop runs on the oscillator clock. The system clock is represented by a clock-enable strobe, `sys_tick`. This strobe is high on every oscillator cycle when the divide strap is 0, and on one cycle in eight when the strap is 1. While halt is active the strobe is held low, so the period count and any pulse in progress are frozen. The halt-exit pulse starts on the first system-clock strobe after the halt flag drops. Any pulse restarts the period count from zero. A new trigger that arrives during an active pulse reloads its full width.

Top module: `auto_reset_gen`

## Requirements
- R1: While `por_ok` is low, `rst_out` is high from the third oscillator edge at the latest, and `sys_tick` is low. `por_ok` passes through a two-flop synchronizer.
- R2: After `por_ok` rises, `rst_out` stays high until PULSE_LEN (8) system-clock strobes have occurred, and then falls. With `div_sel`=0 the first low sample follows the 10th edge after the rise. With `div_sel`=1 it follows the 66th edge.
- R3: With no halt activity, a pulse starts on the strobe that completes 2^PERIOD_LOG2 strobes since the previous pulse started. Successive rising edges of `rst_out` are therefore 2^PERIOD_LOG2 strobes apart, and each such pulse lasts 8 strobes.
- R4: On the first strobe after `halt_req` falls, a pulse of 8 strobes starts. With `div_sel`=0, `rst_out` is high after the first edge that follows the fall.
- R5: While `halt_req` is high, `sys_tick` is low and the period count and pulse count hold their values, so `rst_out` does not change.
- R6: `div_sel`=0 gives a strobe on every oscillator cycle that is out of reset and not halted. `div_sel`=1 gives one strobe per 8 such cycles, counted from the release of power-on reset.
- R7: Every pulse, whether periodic or from a halt exit, clears the period count. The next periodic pulse therefore starts 2^PERIOD_LOG2 strobes after the latest pulse start.
- R8: A halt exit during an active pulse reloads the full width. `rst_out` stays high and falls 8 strobes after the retrigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all state is clocked on its rising edge |
| div_sel | input | 1 | Static divide strap: 0 gives fxx = oscillator, 1 gives fxx = oscillator / 8 |
| por_ok | input | 1 | Supply-good level from the analog detector, asynchronous; low holds reset |
| halt_req | input | 1 | High while the device is in halt mode |
| rst_out | output | 1 | Registered active-high reset pulse |
| sys_tick | output | 1 | System-clock enable strobe (fxx) |

## Verification
The hardest case to reach is a halt exit that lands while a pulse is already running, because the block is halted for only a few strobes inside an 8-strobe window. The directed stimulus waits for a periodic pulse to begin, enters halt two cycles later and leaves it five cycles after that. It then checks that the pulse is stretched instead of ending early. The random phase toggles halt with short random lengths and occasionally drops `por_ok` and flips the strap while reset is held. A per-cycle reference model in the bench compares `rst_out` and `sys_tick` throughout. A shortened period keeps several full periods inside the run.

// File: rtl/ar_pkg.sv
package ar_pkg;
    localparam int DEF_PERIOD_LOG2 = 17;
    localparam int DEF_PULSE_LEN   = 8;
    localparam int DEF_DIV_LOG2    = 3;
    localparam int DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic period_wrap;
        logic halt_exit;
    } trig_t;

    function automatic logic trig_any(trig_t t);
        return t.period_wrap | t.halt_exit;
    endfunction
endpackage

// File: rtl/ar_por_sync.sv
module ar_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_ok,
    output logic por_low
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[STAGES-2:0], por_ok};
    end

    assign por_low = ~sync_q[STAGES-1];
endmodule

// File: rtl/ar_prescaler.sv
module ar_prescaler #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic por_low,
    input  logic halt,
    input  logic div_sel,
    output logic tick
);
    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (por_low)
            phase_q <= '0;
        else if (!halt)
            phase_q <= phase_q + 1'b1;
    end

    logic phase_hit;
    assign phase_hit = div_sel ? (&phase_q) : 1'b1;
    assign tick      = ~por_low & ~halt & phase_hit;
endmodule

// File: rtl/ar_period_timer.sv
module ar_period_timer #(
    parameter int PERIOD_LOG2 = 17
) (
    input  logic                   clk,
    input  logic                   por_low,
    input  logic                   tick,
    input  logic                   clear,
    output logic                   wrap,
    output logic [PERIOD_LOG2-1:0] count
);
    localparam logic [PERIOD_LOG2-1:0] CNT_LAST = '1;

    always_ff @(posedge clk) begin
        if (por_low || clear)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end

    assign wrap = tick & (count == CNT_LAST);
endmodule

// File: rtl/ar_halt_exit.sv
module ar_halt_exit (
    input  logic clk,
    input  logic por_low,
    input  logic halt,
    input  logic tick,
    output logic exit_pulse,
    output logic halt_seen
);
    always_ff @(posedge clk) begin
        if (por_low)
            halt_seen <= 1'b0;
        else if (halt)
            halt_seen <= 1'b1;
        else if (tick)
            halt_seen <= 1'b0;
    end

    assign exit_pulse = tick & halt_seen;
endmodule

// File: rtl/ar_pulse_shaper.sv
module ar_pulse_shaper #(
    parameter int PULSE_LEN = 8
) (
    input  logic          clk,
    input  logic          por_low,
    input  logic          tick,
    input  ar_pkg::trig_t trig,
    output logic          rst_q,
    output logic [$clog2(PULSE_LEN+1)-1:0] remain
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

    logic [CW-1:0] remain_nxt;

    always_comb begin
        remain_nxt = remain;
        if (por_low || ar_pkg::trig_any(trig))
            remain_nxt = LOAD;
        else if (tick && remain != '0)
            remain_nxt = remain - 1'b1;
    end

    always_ff @(posedge clk) begin
        remain <= remain_nxt;
        rst_q  <= (remain_nxt != '0);
    end
endmodule

// File: rtl/auto_reset_gen.sv
module auto_reset_gen #(
    parameter int PERIOD_LOG2 = ar_pkg::DEF_PERIOD_LOG2,
    parameter int PULSE_LEN   = ar_pkg::DEF_PULSE_LEN,
    parameter int DIV_LOG2    = ar_pkg::DEF_DIV_LOG2,
    parameter int SYNC_STAGES = ar_pkg::DEF_SYNC_STAGES
) (
    input  logic clk_osc,
    input  logic div_sel,
    input  logic por_ok,
    input  logic halt_req,
    output logic rst_out,
    output logic sys_tick
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic                   por_low;
    logic                   tick;
    logic                   halt_seen;
    logic [PERIOD_LOG2-1:0] per_cnt;
    logic [CW-1:0]          pw_cnt;
    ar_pkg::trig_t          trig;

    ar_por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_osc), .por_ok(por_ok), .por_low(por_low)
    );

    ar_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk_osc), .por_low(por_low), .halt(halt_req),
        .div_sel(div_sel), .tick(tick)
    );

    ar_period_timer #(.PERIOD_LOG2(PERIOD_LOG2)) u_per (
        .clk(clk_osc), .por_low(por_low), .tick(tick),
        .clear(ar_pkg::trig_any(trig)), .wrap(trig.period_wrap),
        .count(per_cnt)
    );

    ar_halt_exit u_hx (
        .clk(clk_osc), .por_low(por_low), .halt(halt_req), .tick(tick),
        .exit_pulse(trig.halt_exit), .halt_seen(halt_seen)
    );

    ar_pulse_shaper #(.PULSE_LEN(PULSE_LEN)) u_pw (
        .clk(clk_osc), .por_low(por_low), .tick(tick), .trig(trig),
        .rst_q(rst_out), .remain(pw_cnt)
    );

    assign sys_tick = tick;
endmodule

// File: rtl/auto_reset_chk.sv
module auto_reset_chk #(
    parameter int PERIOD_LOG2 = 17,
    parameter int PULSE_LEN   = 8
) (
    input logic                   clk,
    input logic                   por_low,
    input logic                   halt_req,
    input logic                   div_sel,
    input logic                   sys_tick,
    input logic                   rst_out,
    input logic                   halt_seen,
    input logic [PERIOD_LOG2-1:0] per_cnt,
    input logic [$clog2(PULSE_LEN+1)-1:0] pw_cnt
);
    // R1
    por_hold_chk: assert property (@(posedge clk)
        por_low |=> rst_out);

    // R2
    pulse_end_chk: assert property (@(posedge clk) disable iff (por_low)
        $fell(rst_out) |-> $past(pw_cnt) == 1);

    // R3
    period_fire_chk: assert property (@(posedge clk) disable iff (por_low)
        (sys_tick && per_cnt == '1) |=> (rst_out && per_cnt == '0));

    // R4
    halt_exit_chk: assert property (@(posedge clk) disable iff (por_low)
        (sys_tick && halt_seen) |=> (rst_out && pw_cnt == PULSE_LEN));

    // R5
    halt_freeze_chk: assert property (@(posedge clk) disable iff (por_low)
        halt_req |=> ($stable(per_cnt) && $stable(pw_cnt) && $stable(rst_out)));

    // R6
    div_gap_chk: assert property (@(posedge clk) disable iff (por_low)
        (div_sel && sys_tick) |=> !sys_tick);
endmodule

bind auto_reset_gen auto_reset_chk #(
    .PERIOD_LOG2(PERIOD_LOG2), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk(clk_osc), .por_low(por_low), .halt_req(halt_req),
    .div_sel(div_sel), .sys_tick(sys_tick), .rst_out(rst_out),
    .halt_seen(halt_seen), .per_cnt(per_cnt), .pw_cnt(pw_cnt)
);

// File: tb/tb_auto_reset_gen.sv
module tb_auto_reset_gen;
    localparam int PLOG = 8;
    localparam int P    = 1 << PLOG;
    localparam int LEN  = 8;

    logic clk = 1'b0;
    logic div_sel = 1'b0, por_ok = 1'b0, halt_req = 1'b0;
    logic rst_out, sys_tick;
    int   checks = 0, fails = 0;
    int   cyc = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    auto_reset_gen #(.PERIOD_LOG2(PLOG), .PULSE_LEN(LEN)) dut (
        .clk_osc(clk), .div_sel(div_sel), .por_ok(por_ok),
        .halt_req(halt_req), .rst_out(rst_out), .sys_tick(sys_tick)
    );

    // reference model, stepped per oscillator edge from the requirements
    logic [1:0] m_s = 2'b00;
    logic [2:0] m_ph = 3'd0;
    bit         m_hm = 0;
    int         m_per = 0, m_pw = LEN;

    function automatic bit exp_tick(bit por_low, bit h, bit d, logic [2:0] ph);
        return !por_low && !h && (d ? (ph == 3'd7) : 1'b1);
    endfunction

    always @(posedge clk) begin
        bit pl, tk, fire;
        cyc++;
        pl   = !m_s[1];
        tk   = exp_tick(pl, halt_req, div_sel, m_ph);
        fire = tk && (m_hm || m_per == P - 1);
        m_s  = {m_s[0], por_ok};
        if (pl) begin
            m_ph = 0; m_per = 0; m_hm = 0; m_pw = LEN;
        end else begin
            if (!halt_req) m_ph = m_ph + 3'd1;
            m_hm  = halt_req ? 1'b1 : (tk ? 1'b0 : m_hm);
            m_per = fire ? 0 : (tk ? m_per + 1 : m_per);
            m_pw  = fire ? LEN : ((tk && m_pw != 0) ? m_pw - 1 : m_pw);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // edge monitor and per-cycle model comparison
    int rises = 0, falls = 0, rise_cyc = 0, prev_rise = 0, fall_cyc = 0;
    logic prev_rst = 1'b0;
    int tick_cnt = 0;
    always @(negedge clk) begin
        if (cyc > 0) begin
            check("R5/R6 sys_tick model", int'(sys_tick),
                  int'(exp_tick(!m_s[1], halt_req, div_sel, m_ph)));
            check("R3/R4/R7/R8 rst_out model", int'(rst_out), int'(m_pw != 0));
        end
        if (sys_tick) tick_cnt++;
        if (rst_out && !prev_rst) begin prev_rise = rise_cyc; rise_cyc = cyc; rises++; end
        if (!rst_out && prev_rst) begin fall_cyc = cyc; falls++; end
        prev_rst = rst_out;
    end

    task automatic wait_rise();
        int r0 = rises;
        while (rises == r0) @(posedge clk);
    endtask
    task automatic wait_fall();
        int f0 = falls;
        while (falls == f0) @(posedge clk);
    endtask
    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int rel, h, f0, t0;
        // R1: held in reset while supply is not good
        cycles(6);
        check("R1 rst_out during por", int'(rst_out), 1);
        check("R1 sys_tick during por", int'(sys_tick), 0);

        // R2: release, div_sel=0
        @(negedge clk); por_ok = 1'b1; rel = cyc;
        wait_fall();
        check("R2 por release tail div1", fall_cyc - rel, 10);
        // R3: first periodic pulse, width, interval
        wait_rise();
        check("R3 first periodic rise", rise_cyc - rel, P + 2);
        wait_fall();
        check("R3 periodic width div1", fall_cyc - rise_cyc, LEN);
        wait_rise();
        check("R3 periodic interval div1", rise_cyc - prev_rise, P);
        wait_fall();

        // R5 and R4: halt freezes, exit fires
        cycles(20);
        @(negedge clk); halt_req = 1'b1;
        t0 = tick_cnt; f0 = rises;
        cycles(50);
        check("R5 no strobes in halt", tick_cnt - t0, 0);
        check("R5 no pulse in halt", rises - f0, 0);
        @(negedge clk); halt_req = 1'b0; h = cyc;
        wait_rise();
        check("R4 halt exit latency", rise_cyc - h, 1);
        wait_fall();
        check("R4 halt exit width", fall_cyc - rise_cyc, LEN);
        // R7: count restarted by the halt-exit pulse
        wait_rise();
        check("R7 period after halt exit", rise_cyc - prev_rise, P);

        // R8: retrigger during an active pulse
        cycles(2);
        @(negedge clk); halt_req = 1'b1;
        f0 = falls;
        cycles(5);
        @(negedge clk); halt_req = 1'b0; h = cyc;
        wait_fall();
        check("R8 no early fall", falls - f0, 1);
        check("R8 stretched end", fall_cyc - h, LEN + 1);

        // R2, R6, R3 with divide by 8
        @(negedge clk); por_ok = 1'b0; div_sel = 1'b1;
        cycles(5);
        check("R1 rst_out after por drop", int'(rst_out), 1);
        @(negedge clk); por_ok = 1'b1; rel = cyc;
        wait_fall();
        check("R2 por release tail div8", fall_cyc - rel, 66);
        t0 = tick_cnt;
        cycles(800);
        check("R6 strobe rate div8", tick_cnt - t0, 100);
        wait_rise();
        wait_fall();
        check("R3 periodic width div8", fall_cyc - rise_cyc, LEN * 8);
        wait_rise();
        check("R3 periodic interval div8", rise_cyc - prev_rise, P * 8);

        // R6 div1 rate
        @(negedge clk); por_ok = 1'b0; div_sel = 1'b0;
        cycles(4);
        @(negedge clk); por_ok = 1'b1;
        cycles(5);
        t0 = tick_cnt;
        cycles(100);
        check("R6 strobe rate div1", tick_cnt - t0, 100);

        // constrained random: halts, occasional power dips, strap flips under reset
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 600; k++) begin
            int sel = $urandom_range(0, 19);
            if (sel == 0) begin
                @(negedge clk); por_ok = 1'b0;
                cycles($urandom_range(1, 4));
                div_sel = $urandom_range(0, 1) != 0;
                cycles($urandom_range(1, 4));
                por_ok = 1'b1;
            end else if (sel < 8) begin
                @(negedge clk); halt_req = 1'b1;
                cycles($urandom_range(1, 12));
                halt_req = 1'b0;
            end
            cycles($urandom_range(1, 60));
        end
        cycles(20);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule